// File: doc/BRIEF.md
# Memory Supply Range Switch Sequencer

This block sits between a memory controller's command scheduler and a DDR3-class device whose supply can be moved between the 1.35V and 1.5V ranges while running. A request naming the target range starts a fixed sequence. The block first waits for every bank to be closed. It then moves the supply-select pin and lets only idle commands reach the device until the supply monitor reports the new rail in regulation. After that it issues its own DLL-reset mode-register write and a long ZQ calibration, and it stalls READ commands until both the relock wait and the calibration wait have run out.

The scheduler's command stream enters through a valid/ready port. A command is accepted in a cycle where `up_valid` and `up_ready` are both high. Its valid, command, bank and address must stay stable until then. `up_ready` depends only on the present state and on the command on offer. Back-pressure therefore falls on single commands, and the scheduler may offer a different command in a later cycle. Accepted commands reach the device pins one cycle later through a register. Commands are encoded as {cs_n, ras_n, cas_n, we_n}.

Top module: `vsw_seq`

## Requirements
- R1: During and straight after reset: `busy`=0, `dev_cmd`=NOP (4'b0111), `dev_ba`=0, `dev_addr`=0, `up_ready`=1, and `sel_high` equals parameter RESET_HIGH.
- R2: With the block idle, `chg_req`=1 latches `chg_high` as the target, and `busy` is 1 from the next cycle on. A request made while `busy` is 1 changes neither the target nor the sequence.
- R3: The switch waits for a cycle with `banks_idle`=1 and no accepted non-idle command. Until that cycle every command, READ included, is accepted as usual.
- R4: At the switch, `sel_high` takes the target (1 = 1.5V, 0 = 1.35V). From then until the supply is stable, only NOP (4'b0111) and deselect (cs_n=1) are accepted; `up_ready` is 0 for any other command.
- R5: After the switch the block waits for `supply_ok` to go low and then high. A `supply_ok` that stays high from before the switch does not end the wait.
- R6: Once the supply is stable, the device receives an MRS (4'b0000, bank 0, address MR0_VAL with bit 8 set) and in the next cycle a ZQCL (4'b0110, address bit 10 set). `up_ready` is 0 in both of the cycles in which these are chosen.
- R7: From the cycle in which ZQCL is on the pins, non-READ commands are accepted again, but READ (4'b0101) is not.
- R8: Let k0 be the first cycle with `supply_ok` high after it went low. The earliest cycle in which a READ is accepted is k0 + max(T_ZQ, T_DLL+1) + 2, and `busy` falls in that same cycle.
- R9: Lowering (1.5V to 1.35V) and raising (1.35V to 1.5V) run the same sequence with the same timing.
- R10: While idle, an accepted command appears unchanged on `dev_cmd`/`dev_ba`/`dev_addr` one cycle later. A cycle with nothing accepted drives NOP with a zero bank and a zero address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chg_req | input | 1 | Request a supply range change |
| chg_high | input | 1 | Target range: 1 = 1.5V, 0 = 1.35V |
| banks_idle | input | 1 | All banks precharged, including accepted commands |
| supply_ok | input | 1 | Rail in regulation at the selected level |
| up_valid | input | 1 | Upstream command valid |
| up_ready | output | 1 | Upstream command accepted this cycle if valid |
| up_cmd | input | 4 | Upstream command {cs_n, ras_n, cas_n, we_n} |
| up_ba | input | BA_W | Upstream bank address |
| up_addr | input | ADDR_W | Upstream row/column address |
| dev_cmd | output | 4 | Registered command to the device |
| dev_ba | output | BA_W | Registered bank address to the device |
| dev_addr | output | ADDR_W | Registered address to the device |
| sel_high | output | 1 | Supply select: 1 = 1.5V, 0 = 1.35V |
| busy | output | 1 | Change sequence in progress |

## Verification
The bench builds the block with T_DLL=8 and T_ZQ=12 in place of the 512-cycle defaults. Both waits then end within about a dozen cycles, so the exact cycle of the first READ accept can be checked. With these values the calibration wait is the longer one, and the R8 formula gives cycle k0+14. The short waits also let one run cover a lowering change followed by a raising change.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PRE,
    ST_SWITCH,
    ST_WAIT_STABLE,
    ST_DLL_RST,
    ST_ZQCL,
    ST_WAIT_TMR
  } vsw_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_READ = 4'b0101;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
  localparam logic [3:0] CMD_ZQ   = 4'b0110;

  localparam int DLL_RST_BIT = 8;
  localparam int ZQ_LONG_BIT = 10;

  function automatic logic cmd_is_idle(input logic [3:0] c);
    return c[3] || (c == CMD_NOP);
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] c);
    return (c == CMD_READ);
  endfunction

endpackage

// File: rtl/vsw_timer.sv
module vsw_timer #(
  parameter int CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= W'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/vsw_fsm.sv
module vsw_fsm
  import vsw_pkg::*;
#(
  parameter bit RESET_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chg_req,
  input  logic       chg_high,
  input  logic       banks_idle,
  input  logic       supply_ok,
  input  logic       nonidle_fire,
  input  logic       timers_done,
  output vsw_state_e state,
  output logic       sel_high,
  output logic       zq_start,
  output logic       dll_start
);
  vsw_state_e nxt;
  logic       tgt_high;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:        if (chg_req) nxt = ST_WAIT_PRE;
      ST_WAIT_PRE:    if (banks_idle && !nonidle_fire) nxt = ST_SWITCH;
      ST_SWITCH:      if (!supply_ok) nxt = ST_WAIT_STABLE;
      ST_WAIT_STABLE: if (supply_ok) nxt = ST_DLL_RST;
      ST_DLL_RST:     nxt = ST_ZQCL;
      ST_ZQCL:        nxt = ST_WAIT_TMR;
      ST_WAIT_TMR:    if (timers_done) nxt = ST_IDLE;
      default:        nxt = ST_IDLE;
    endcase
  end

  assign zq_start  = (state == ST_WAIT_STABLE) && supply_ok;
  assign dll_start = (state == ST_DLL_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tgt_high <= RESET_HIGH;
      sel_high <= RESET_HIGH;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && chg_req) tgt_high <= chg_high;
      if (state == ST_WAIT_PRE && nxt == ST_SWITCH) sel_high <= tgt_high;
    end
  end
endmodule

// File: rtl/vsw_gate.sv
module vsw_gate
  import vsw_pkg::*;
#(
  parameter int          ADDR_W  = 14,
  parameter int          BA_W    = 3,
  parameter int unsigned MR0_VAL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vsw_state_e        state,
  input  logic              up_valid,
  input  logic [3:0]        up_cmd,
  input  logic [BA_W-1:0]   up_ba,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              up_ready,
  output logic              nonidle_fire,
  output logic [3:0]        dev_cmd,
  output logic [BA_W-1:0]   dev_ba,
  output logic [ADDR_W-1:0] dev_addr
);
  localparam logic [ADDR_W-1:0] MRS_ADDR =
    ADDR_W'(MR0_VAL) | (ADDR_W'(1) << DLL_RST_BIT);
  localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(1) << ZQ_LONG_BIT;

  logic fire;

  always_comb begin
    unique case (state)
      ST_IDLE, ST_WAIT_PRE:      up_ready = 1'b1;
      ST_SWITCH, ST_WAIT_STABLE: up_ready = cmd_is_idle(up_cmd);
      ST_WAIT_TMR:               up_ready = !cmd_is_read(up_cmd);
      default:                   up_ready = 1'b0;
    endcase
  end

  assign fire         = up_valid && up_ready;
  assign nonidle_fire = fire && !cmd_is_idle(up_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_cmd  <= CMD_NOP;
      dev_ba   <= '0;
      dev_addr <= '0;
    end else if (state == ST_DLL_RST) begin
      dev_cmd  <= CMD_MRS;
      dev_ba   <= '0;
      dev_addr <= MRS_ADDR;
    end else if (state == ST_ZQCL) begin
      dev_cmd  <= CMD_ZQ;
      dev_ba   <= '0;
      dev_addr <= ZQ_ADDR;
    end else if (fire) begin
      dev_cmd  <= up_cmd;
      dev_ba   <= up_ba;
      dev_addr <= up_addr;
    end else begin
      dev_cmd  <= CMD_NOP;
      dev_ba   <= '0;
      dev_addr <= '0;
    end
  end
endmodule

// File: rtl/vsw_seq.sv
module vsw_seq
  import vsw_pkg::*;
#(
  parameter int          ADDR_W     = 14,
  parameter int          BA_W       = 3,
  parameter int          T_DLL      = 512,
  parameter int          T_ZQ       = 512,
  parameter int unsigned MR0_VAL    = 0,
  parameter bit          RESET_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_req,
  input  logic              chg_high,
  input  logic              banks_idle,
  input  logic              supply_ok,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [3:0]        up_cmd,
  input  logic [BA_W-1:0]   up_ba,
  input  logic [ADDR_W-1:0] up_addr,
  output logic [3:0]        dev_cmd,
  output logic [BA_W-1:0]   dev_ba,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              sel_high,
  output logic              busy
);
  vsw_state_e st;
  logic nonidle_fire, zq_start, dll_start, zq_done, dll_done;

  vsw_fsm #(.RESET_HIGH(RESET_HIGH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .chg_high(chg_high),
    .banks_idle(banks_idle), .supply_ok(supply_ok),
    .nonidle_fire(nonidle_fire), .timers_done(zq_done && dll_done),
    .state(st), .sel_high(sel_high), .zq_start(zq_start),
    .dll_start(dll_start)
  );

  vsw_timer #(.CYCLES(T_DLL)) u_dll_tmr (
    .clk(clk), .rst_n(rst_n), .start(dll_start), .done(dll_done)
  );

  vsw_timer #(.CYCLES(T_ZQ)) u_zq_tmr (
    .clk(clk), .rst_n(rst_n), .start(zq_start), .done(zq_done)
  );

  vsw_gate #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MR0_VAL(MR0_VAL)) u_gate (
    .clk(clk), .rst_n(rst_n), .state(st), .up_valid(up_valid),
    .up_cmd(up_cmd), .up_ba(up_ba), .up_addr(up_addr),
    .up_ready(up_ready), .nonidle_fire(nonidle_fire),
    .dev_cmd(dev_cmd), .dev_ba(dev_ba), .dev_addr(dev_addr)
  );

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/vsw_seq_chk.sv
module vsw_seq_chk
  import vsw_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input vsw_state_e        state,
  input logic              chg_req,
  input logic              banks_idle,
  input logic              up_valid,
  input logic              up_ready,
  input logic [3:0]        up_cmd,
  input logic [3:0]        dev_cmd,
  input logic [BA_W-1:0]   dev_ba,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              sel_high,
  input logic              busy
);
  // R2: busy only rises after a request
  a_r2_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(chg_req));

  // R3: the select pin only moves after a cycle with all banks closed
  a_r3_switch_precharged: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_high) |-> $past(banks_idle));

  // R4: only idle commands pass while the rail settles
  a_r4_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SWITCH || state == ST_WAIT_STABLE) && up_valid && up_ready)
      |-> cmd_is_idle(up_cmd));

  // R6: DLL reset goes to MR0 with the reset bit set, then ZQCL follows
  a_r6_mrs_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cmd == CMD_MRS) |-> (dev_ba == '0 && dev_addr[DLL_RST_BIT]));
  a_r6_zq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cmd == CMD_MRS) |=> (dev_cmd == CMD_ZQ && dev_addr[ZQ_LONG_BIT]));

  // R8: no READ accepted once the switch has begun and busy is still set
  a_r8_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_WAIT_PRE && up_valid && up_ready)
      |-> !cmd_is_read(up_cmd));
endmodule

bind vsw_seq vsw_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(st), .chg_req(chg_req),
  .banks_idle(banks_idle), .up_valid(up_valid), .up_ready(up_ready),
  .up_cmd(up_cmd), .dev_cmd(dev_cmd), .dev_ba(dev_ba),
  .dev_addr(dev_addr), .sel_high(sel_high), .busy(busy)
);

// File: tb/tb_vsw_seq.sv
module tb_vsw_seq;
  localparam int ADDR_W = 14;
  localparam int BA_W   = 3;
  localparam int T_DLL  = 8;
  localparam int T_ZQ   = 12;
  localparam int unsigned MR0 = 32'h0521;
  localparam int READ_AT = ((T_ZQ > T_DLL + 1) ? T_ZQ : T_DLL + 1) + 2;

  localparam logic [3:0] NOP = 4'b0111, RD = 4'b0101, WR = 4'b0100,
                         ACT = 4'b0011, PRE = 4'b0010, DES = 4'b1000,
                         MRS = 4'b0000, ZQC = 4'b0110;

  // {valid, cmd, ba, addr}
  localparam int VW = 1 + 4 + BA_W + ADDR_W;
  localparam int NV = 6;
  localparam logic [NV-1:0][VW-1:0] VEC = {
    {1'b0, WR,  3'd5, 14'h3fff},
    {1'b1, DES, 3'd0, 14'h0000},
    {1'b1, PRE, 3'd0, 14'h0400},
    {1'b1, RD,  3'd2, 14'h0011},
    {1'b1, WR,  3'd1, 14'h0400},
    {1'b1, ACT, 3'd3, 14'h1234}
  };

  logic clk = 0, rst_n = 0;
  logic chg_req = 0, chg_high = 0, banks_idle = 1, supply_ok = 1;
  logic up_valid = 0;
  logic [3:0] up_cmd = NOP;
  logic [BA_W-1:0] up_ba = '0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic up_ready, sel_high, busy;
  logic [3:0] dev_cmd;
  logic [BA_W-1:0] dev_ba;
  logic [ADDR_W-1:0] dev_addr;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  vsw_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .T_DLL(T_DLL), .T_ZQ(T_ZQ),
            .MR0_VAL(MR0), .RESET_HIGH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .chg_high(chg_high),
    .banks_idle(banks_idle), .supply_ok(supply_ok), .up_valid(up_valid),
    .up_ready(up_ready), .up_cmd(up_cmd), .up_ba(up_ba), .up_addr(up_addr),
    .dev_cmd(dev_cmd), .dev_ba(dev_ba), .dev_addr(dev_addr),
    .sel_high(sel_high), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic offer(input logic v, input logic [3:0] c);
    up_valid = v; up_cmd = c; up_ba = '0; up_addr = '0;
  endtask

  // Drives a supply rise and walks the tail of the sequence. Returns the
  // cycle offset of the first READ accept.
  task automatic tail(input string tag, input bit probe_wr, output int first);
    first = -1;
    supply_ok = 1;
    offer(1'b1, probe_wr ? WR : RD);
    for (int j = 1; j <= 40; j++) begin
      nx(); #1;
      if (j == 2) begin
        chk({tag, " R6 mrs cmd"}, dev_cmd, MRS);
        chk({tag, " R6 mrs addr"}, dev_addr, MR0 | 32'h100);
        chk({tag, " R6 mrs ba"}, dev_ba, 0);
        chk({tag, " R6 ready low"}, up_ready, 0);
      end
      if (j == 3) begin
        chk({tag, " R6 zqcl cmd"}, dev_cmd, ZQC);
        chk({tag, " R6 zqcl a10"}, dev_addr[10], 1);
        if (probe_wr) begin
          chk({tag, " R7 write released"}, up_ready, 1);
          offer(1'b1, RD); #0.5;
          chk({tag, " R7 read held"}, up_ready, 0);
        end
        continue;
      end
      if (j > 3 && up_ready && up_cmd == RD) begin
        first = j;
        chk({tag, " R8 busy drops with read"}, busy, 0);
        break;
      end
      if (j > 3) chk({tag, " R8 busy while held"}, busy, 1);
    end
    nx(); #1;
    chk({tag, " R8 read reaches pins"}, dev_cmd, RD);
    offer(1'b0, NOP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int first;
    repeat (3) nx();
    #0.5;
    chk("R1 busy in reset", busy, 0);
    chk("R1 dev_cmd in reset", dev_cmd, NOP);
    rst_n = 1;
    nx(); #1;
    chk("R1 busy", busy, 0);
    chk("R1 dev_cmd", dev_cmd, NOP);
    chk("R1 dev_addr", dev_addr, 0);
    chk("R1 sel_high", sel_high, 1);
    chk("R1 up_ready", up_ready, 1);

    // R10: idle pass-through table
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      nx();
      up_valid = v[VW-1]; up_cmd = v[VW-2 -: 4];
      up_ba = v[ADDR_W +: BA_W]; up_addr = v[ADDR_W-1:0];
      #1;
      chk("R10 ready idle", up_ready, 1);
      nx(); #1;
      chk("R10 dev_cmd", dev_cmd, v[VW-1] ? v[VW-2 -: 4] : NOP);
      chk("R10 dev_ba", dev_ba, v[VW-1] ? v[ADDR_W +: BA_W] : 0);
      chk("R10 dev_addr", dev_addr, v[VW-1] ? v[ADDR_W-1:0] : 0);
    end

    // Lowering run
    nx(); offer(1'b0, NOP);
    banks_idle = 0; chg_req = 1; chg_high = 0;
    nx(); chg_req = 0; #1;
    chk("R2 busy after request", busy, 1);
    offer(1'b1, WR); #0.5;
    chk("R3 write flows before switch", up_ready, 1);
    nx();
    chg_req = 1; chg_high = 1;   // ignored: busy
    banks_idle = 1;              // WRITE still accepted in this cycle
    nx(); chg_req = 0; #1;
    chk("R3 no switch while command accepted", sel_high, 1);
    offer(1'b0, NOP);
    nx(); #1;
    chk("R4 sel lowered", sel_high, 0);
    offer(1'b1, WR); #0.5;
    chk("R4 write blocked", up_ready, 0);
    offer(1'b1, NOP); #0.5;
    chk("R4 nop passes", up_ready, 1);
    offer(1'b1, DES); #0.5;
    chk("R4 deselect passes", up_ready, 1);
    offer(1'b1, WR);
    repeat (3) nx();
    #1;
    chk("R5 stale supply_ok keeps gate", up_ready, 0);
    chk("R5 no mrs yet", dev_cmd, NOP);
    supply_ok = 0;
    repeat (2) nx();
    #1;
    chk("R5 gate while rail low", up_ready, 0);
    tail("lower", 1'b0, first);
    chk("R8 first read cycle lower", first, READ_AT);
    chk("R2 ignored request kept target", sel_high, 0);
    chk("R2 back to idle", busy, 0);

    // Raising run
    nx();
    chg_req = 1; chg_high = 1; banks_idle = 1;
    nx(); chg_req = 0; #1;
    chk("R9 busy raise", busy, 1);
    nx(); #1;
    chk("R9 sel raised", sel_high, 1);
    supply_ok = 0;
    repeat (2) nx();
    tail("raise", 1'b1, first);
    chk("R9 first read cycle raise", first, READ_AT);
    chk("R9 sel stays high", sel_high, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule